// File: doc/BRIEF.md
# Idle Ordered Set Generator

This block sits in front of an 8B/10B encoder and supplies idle ordered sets at the octet level. Each set has two symbols. The first is the K28.5 comma (octet 0xBC with the control flag set). The second is a data character. The block picks that data character from the link's running disparity so that every idle set leaves the line with negative disparity.

The encoder downstream feeds back each 10-bit code-group it emits, and the block keeps its running disparity register up to date from that stream. Symbols go out on a valid/ready handshake. A pending `idle_req` starts a set. Once a set has started it always finishes, and a set that is still requested follows the previous one with no idle cycle between them.

Top module: `idle_os_gen`

## Requirements
- R1: After reset `sym_valid` is 0 and `rd_positive` is 0, meaning the disparity starts negative.
- R2: In the cycle after `idle_req` is sampled high with no set in progress, the comma is presented: `sym_valid`=1, `sym_is_k`=1, `sym_octet`=0xBC.
- R3: While `sym_valid` is 1 and `out_ready` is 0, the presented symbol (`sym_octet`, `sym_is_k`) stays unchanged and valid.
- R4: In the cycle after the comma is accepted (`sym_valid` and `out_ready` high), the data character is presented with `sym_is_k`=0 and no gap cycle.
- R5: The data character is 0x50 (D16.2) if `rd_positive` was 0 in the cycle the comma was accepted, and 0xC5 (D5.6) if it was 1. A code-group update in that same cycle or later does not change the choice.
- R6: After the data character is accepted, the next cycle presents a new comma if `idle_req` is high; otherwise `sym_valid` drops to 0.
- R7: A code-group with `cg_valid`=1 updates `rd_positive` on the next cycle. Sub-block 1 is `cg_word[9:4]` and sub-block 2 is `cg_word[3:0]`, applied in that order. A sub-block with more ones than zeros sets the disparity positive, and one with more zeros sets it negative. An unbalanced sub-block 2 therefore decides the result.
- R8: A sub-block with equal ones and zeros leaves the disparity as it was. If both sub-blocks are balanced, or if `cg_valid`=0, `rd_positive` holds.
- R9: Dropping `idle_req` after a comma has been accepted does not cancel that set: the data character is still presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| idle_req | input | 1 | Request for idle ordered sets |
| cg_valid | input | 1 | Qualifies `cg_word` |
| cg_word | input | 10 | Code-group sent on the line, used to track disparity |
| out_ready | input | 1 | Downstream accepts the presented symbol |
| sym_valid | output | 1 | A symbol is presented |
| sym_octet | output | 8 | Octet of the presented symbol |
| sym_is_k | output | 1 | Presented symbol is a control character |
| rd_positive | output | 1 | Current running disparity (1 = positive) |

## Verification
The key overlap is a disparity update from `cg_valid` landing in the same cycle as the comma handshake. The data character must follow the disparity from before that update, even though the register changes at the same edge. The bench forces this case with directed code-groups of opposite disparity. It also produces it many times in a random phase where `cg_valid`, `out_ready` and `idle_req` toggle independently. Each presented character is compared against a bench model that latches its disparity at the handshake.

// File: rtl/idle_os_pkg.sv
package idle_os_pkg;

  typedef enum logic [1:0] {
    ST_REST  = 2'd0,
    ST_COMMA = 2'd1,
    ST_CHAR  = 2'd2
  } ios_state_t;

  typedef enum logic [1:0] {
    SB_NEUTRAL = 2'd0,
    SB_HEAVY1  = 2'd1,
    SB_HEAVY0  = 2'd2
  } sb_weight_t;

  localparam int          OCT_W        = 8;
  localparam logic [7:0]  SYM_COMMA    = 8'hBC;
  localparam logic [7:0]  SYM_CHAR_NEG = 8'h50;
  localparam logic [7:0]  SYM_CHAR_POS = 8'hC5;

endpackage

// File: rtl/subblock_weigh.sv
module subblock_weigh
  import idle_os_pkg::*;
#(
  parameter int W = 6
) (
  input  logic [W-1:0] bits_in,
  output sb_weight_t   weight
);

  int ones;

  always_comb begin
    ones = 0;
    for (int i = 0; i < W; i++) begin
      ones = ones + int'(bits_in[i]);
    end
    if (2 * ones > W) begin
      weight = SB_HEAVY1;
    end else if (2 * ones < W) begin
      weight = SB_HEAVY0;
    end else begin
      weight = SB_NEUTRAL;
    end
  end

endmodule

// File: rtl/rd_tracker.sv
module rd_tracker
  import idle_os_pkg::*;
#(
  parameter int CG_W  = 10,
  parameter int SB1_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cg_valid,
  input  logic [CG_W-1:0] cg_word,
  output logic            rd_pos
);

  localparam int SB2_W = CG_W - SB1_W;

  sb_weight_t w_first;
  sb_weight_t w_second;
  logic       rd_mid;
  logic       rd_next;

  subblock_weigh #(.W(SB1_W)) u_first (
    .bits_in (cg_word[CG_W-1:SB2_W]),
    .weight  (w_first)
  );

  subblock_weigh #(.W(SB2_W)) u_second (
    .bits_in (cg_word[SB2_W-1:0]),
    .weight  (w_second)
  );

  // Sub-block 1 is applied first, then sub-block 2 on its result.
  always_comb begin
    case (w_first)
      SB_HEAVY1: rd_mid = 1'b1;
      SB_HEAVY0: rd_mid = 1'b0;
      default:   rd_mid = rd_pos;
    endcase
    case (w_second)
      SB_HEAVY1: rd_next = 1'b1;
      SB_HEAVY0: rd_next = 1'b0;
      default:   rd_next = rd_mid;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pos <= 1'b0;
    end else if (cg_valid) begin
      rd_pos <= rd_next;
    end
  end

  // R7: an unbalanced second sub-block sets the disparity sign
  a_r7_second_heavy1: assert property (@(posedge clk) disable iff (!rst_n)
    (cg_valid && w_second == SB_HEAVY1) |=> rd_pos);
  a_r7_second_heavy0: assert property (@(posedge clk) disable iff (!rst_n)
    (cg_valid && w_second == SB_HEAVY0) |=> !rd_pos);
  // R8: balanced code-groups or no update keep the disparity
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cg_valid || (w_first == SB_NEUTRAL && w_second == SB_NEUTRAL)) |=> $stable(rd_pos));

endmodule

// File: rtl/idle_seq.sv
module idle_seq
  import idle_os_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             out_ready,
  input  logic             rd_pos,
  output logic             sym_valid,
  output logic [OCT_W-1:0] sym_octet,
  output logic             sym_is_k
);

  ios_state_t state_q, state_d;
  logic       pick_pos_q, pick_pos_d;
  logic       pick_en;

  always_comb begin
    state_d = state_q;
    pick_en = 1'b0;
    case (state_q)
      ST_REST: begin
        if (idle_req) state_d = ST_COMMA;
      end
      ST_COMMA: begin
        if (out_ready) begin
          state_d = ST_CHAR;
          pick_en = 1'b1;
        end
      end
      ST_CHAR: begin
        if (out_ready) state_d = idle_req ? ST_COMMA : ST_REST;
      end
      default: state_d = ST_REST;
    endcase
    pick_pos_d = pick_en ? rd_pos : pick_pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_REST;
      pick_pos_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      pick_pos_q <= pick_pos_d;
    end
  end

  always_comb begin
    sym_valid = (state_q != ST_REST);
    sym_is_k  = (state_q == ST_COMMA);
    case (state_q)
      ST_COMMA: sym_octet = SYM_COMMA;
      ST_CHAR:  sym_octet = pick_pos_q ? SYM_CHAR_POS : SYM_CHAR_NEG;
      default:  sym_octet = '0;
    endcase
  end

  // R3: a stalled symbol is held
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !out_ready) |=> (sym_valid && $stable(sym_octet) && $stable(sym_is_k)));
  // R4: accepted comma is followed at once by the data character
  a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_is_k && out_ready) |=> (sym_valid && !sym_is_k));
  // R5: character choice from disparity at comma acceptance
  a_r5_pick_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_is_k && out_ready && !rd_pos) |=> (sym_octet == SYM_CHAR_NEG));
  a_r5_pick_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_is_k && out_ready && rd_pos) |=> (sym_octet == SYM_CHAR_POS));
  // R6: request low after an accepted data character ends the run
  a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_is_k && out_ready && !idle_req) |=> !sym_valid);

endmodule

// File: rtl/idle_os_gen.sv
module idle_os_gen
  import idle_os_pkg::*;
#(
  parameter int CG_W  = 10,
  parameter int SB1_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle_req,
  input  logic            cg_valid,
  input  logic [CG_W-1:0] cg_word,
  input  logic            out_ready,
  output logic            sym_valid,
  output logic [7:0]      sym_octet,
  output logic            sym_is_k,
  output logic            rd_positive
);

  logic rd_pos;

  rd_tracker #(.CG_W(CG_W), .SB1_W(SB1_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cg_valid (cg_valid),
    .cg_word  (cg_word),
    .rd_pos   (rd_pos)
  );

  idle_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_req  (idle_req),
    .out_ready (out_ready),
    .rd_pos    (rd_pos),
    .sym_valid (sym_valid),
    .sym_octet (sym_octet),
    .sym_is_k  (sym_is_k)
  );

  assign rd_positive = rd_pos;

endmodule

// File: tb/idle_os_gen_test.sv
module idle_os_gen_test;

  logic       clk;
  logic       rst_n;
  logic       idle_req;
  logic       cg_valid;
  logic [9:0] cg_word;
  logic       out_ready;
  logic       sym_valid;
  logic [7:0] sym_octet;
  logic       sym_is_k;
  logic       rd_positive;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // bench model
  int m_st;   // 0 rest, 1 comma, 2 char
  bit m_rd;
  bit m_sel;

  idle_os_gen uut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .cg_valid(cg_valid),
    .cg_word(cg_word), .out_ready(out_ready), .sym_valid(sym_valid),
    .sym_octet(sym_octet), .sym_is_k(sym_is_k), .rd_positive(rd_positive)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int weigh(input logic [9:0] w, input int lo, input int width);
    int ones = 0;
    for (int i = 0; i < width; i++) ones += int'(w[lo+i]);
    if (2 * ones > width) return 1;
    if (2 * ones < width) return -1;
    return 0;
  endfunction

  function automatic bit rd_after(input bit rd, input logic [9:0] w);
    bit r = rd;
    int a = weigh(w, 4, 6);
    int b = weigh(w, 0, 4);
    if (a > 0) r = 1'b1; else if (a < 0) r = 1'b0;
    if (b > 0) r = 1'b1; else if (b < 0) r = 1'b0;
    return r;
  endfunction

  // Inputs are set at negedge; advance model, cross posedge, compare at negedge.
  task automatic step();
    int nst = m_st;
    if (m_st == 1 && out_ready) m_sel = m_rd;   // R5 pre-update disparity
    case (m_st)
      0: if (idle_req) nst = 1;
      1: if (out_ready) nst = 2;
      2: if (out_ready) nst = idle_req ? 1 : 0;
      default: nst = 0;
    endcase
    m_st = nst;
    if (cg_valid) m_rd = rd_after(m_rd, cg_word);
    @(posedge clk);
    @(negedge clk);
    check(rd_positive == m_rd, "R7", rd_positive, m_rd);
    check(sym_valid == (m_st != 0), "R2", sym_valid, m_st != 0);
    if (m_st == 1) begin
      check(sym_is_k && sym_octet == 8'hBC, "R2", {sym_is_k, sym_octet}, 9'h1BC);
    end else if (m_st == 2) begin
      check(!sym_is_k && sym_octet == (m_sel ? 8'hC5 : 8'h50), "R5",
            {sym_is_k, sym_octet}, m_sel ? 9'h0C5 : 9'h050);
    end
  endtask

  task automatic drive(input bit rq, input bit cv, input logic [9:0] cw, input bit rdy);
    idle_req = rq; cg_valid = cv; cg_word = cw; out_ready = rdy;
    step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; idle_req = 0; cg_valid = 0; cg_word = '0; out_ready = 0;
    m_st = 0; m_rd = 0; m_sel = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sym_valid == 1'b0, "R1", sym_valid, 0);
    check(rd_positive == 1'b0, "R1", rd_positive, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: sub-block 2 decides (sb1 heavy ones, sb2 heavy zeros)
    drive(0, 1, 10'b111111_0000, 0);
    check(rd_positive == 1'b0, "R7", rd_positive, 0);
    // R7: sb1 heavy ones, sb2 balanced -> positive
    drive(0, 1, 10'b110111_1010, 0);
    check(rd_positive == 1'b1, "R7", rd_positive, 1);
    // R8: both balanced -> hold positive
    drive(0, 1, 10'b111000_1100, 0);
    check(rd_positive == 1'b1, "R8", rd_positive, 1);
    // R8: cg_valid low with unbalanced word -> hold
    drive(0, 0, 10'b000000_0000, 0);
    check(rd_positive == 1'b1, "R8", rd_positive, 1);

    // R2 and R3: request, then stall with ready low
    drive(1, 0, '0, 0);
    check(sym_valid && sym_is_k && sym_octet == 8'hBC, "R2", sym_octet, 8'hBC);
    drive(0, 0, '0, 0);
    drive(0, 0, '0, 0);
    check(sym_valid && sym_is_k && sym_octet == 8'hBC, "R3", sym_octet, 8'hBC);
    // R5 concurrency: accept comma while disparity flips to negative; choice uses positive
    // R9: request already low, set still completes
    drive(0, 1, 10'b000000_0000, 1);
    check(sym_valid && !sym_is_k && sym_octet == 8'hC5, "R5", sym_octet, 8'hC5);
    check(sym_valid, "R9", sym_valid, 1);
    // R5: later update does not change the held character
    drive(0, 1, 10'b111111_1111, 0);
    check(sym_octet == 8'hC5, "R5", sym_octet, 8'hC5);
    // R6: accept char with request high -> comma next, no gap
    drive(1, 0, '0, 1);
    check(sym_valid && sym_is_k, "R6", sym_is_k, 1);
    // accept comma with disparity positive but flipped same cycle -> still C5
    drive(1, 1, 10'b000000_0000, 1);
    check(sym_octet == 8'hC5 && !sym_is_k, "R4", sym_octet, 8'hC5);
    // R6: accept char with request low -> valid drops
    drive(0, 0, '0, 1);
    check(!sym_valid, "R6", sym_valid, 0);
    // negative disparity set -> D16.2
    drive(1, 0, '0, 1);
    drive(0, 0, '0, 1);
    check(sym_octet == 8'h50 && !sym_is_k, "R5", sym_octet, 8'h50);
    drive(0, 0, '0, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 4) != 0, ($urandom % 2) != 0, 10'($urandom), ($urandom % 3) != 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule